// File: doc/BRIEF.md
# Host Bridge Legacy Memory Decoder

This block sits between the processor's physical address stream and the memory and PCI targets of a host bridge. For each access strobe it decides where the access goes: to DRAM, to DRAM as read-only, or out to PCI. It also computes the DRAM offset for the access. The legacy area from 640 KB to 1 MB is split into shadow windows, and each window's routing is set through a small byte-wide configuration register file. The video/SMM window at 0xA0000 opens to DRAM under control of two bits and the processor's SMM state. The region between the top of low memory and 4 GB always belongs to PCI. Memory above 4 GB is remapped so that it continues DRAM from the top of low memory.

Each decode result is registered, so it appears one clock after the address strobe. A write that lands in a read-only window does not reach DRAM. Instead it raises a write-blocked flag for that one result cycle. A configuration write changes the map only for accesses that come after it.

The register file has eight bytes. Index 0 holds the attribute of the 0xF0000 window. Indices 1 to 6 hold the attributes of the 16 KB segments. Index 7 is the SMRAM control byte.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset all eight configuration bytes are zero, no result is valid, and every address from 0xA0000 to 0xFFFFF goes to PCI whatever the SMM state is. Addresses below 0xA0000 still go to DRAM.
- R2: `resp_valid` is high exactly in the cycle after a cycle in which `req_valid` was high, and it is low otherwise.
- R3: The window 0xF0000–0xFFFFF takes its 2-bit attribute from bits [5:4] of configuration byte 0.
- R4: The range 0xC0000–0xEFFFF is split into twelve 16 KB segments, and segment i starts at 0xC0000 + i·0x4000. Segment i takes its attribute from configuration byte 1 + i/2. An even i uses bits [1:0] of that byte and an odd i uses bits [5:4].
- R5: The attribute sets the target. Attribute 3 gives DRAM for reads and writes, attribute 1 gives read-only DRAM, and attributes 0 and 2 give PCI. The target encoding on `resp_tgt` is 0 = PCI, 1 = DRAM, 2 = read-only DRAM.
- R6: The window 0xA0000–0xBFFFF goes to DRAM when bit 6 of configuration byte 7 is set, or when `smm_active` is high and bit 3 of byte 7 is set. In every other case it goes to PCI.
- R7: A write to a read-only DRAM window raises `resp_blocked` for its one result cycle. A read of such a window, and any access to another target, leaves `resp_blocked` low.
- R8: Addresses from LOW_TOP up to 4 GB go to PCI. Addresses from 1 MB up to LOW_TOP go to DRAM.
- R9: Addresses from 4 GB up to HIGH_END go to DRAM with offset `addr - 4 GB + LOW_TOP`. Addresses at or above HIGH_END go to PCI.
- R10: A configuration write takes effect for accesses strobed in later cycles. An access strobed in the same cycle as the write still uses the old value.
- R11: For DRAM targets below 4 GB the offset equals the address. For a PCI target the offset is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address strobe |
| req_addr | input | ADDR_W | Physical address |
| req_write | input | 1 | 1 = write access |
| smm_active | input | 1 | Processor is in system management mode |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_idx | input | 3 | Configuration byte index (0..7) |
| cfg_data | input | 8 | Configuration byte write data |
| resp_valid | output | 1 | Decode result valid |
| resp_tgt | output | 2 | Target: 0 PCI, 1 DRAM, 2 read-only DRAM |
| resp_off | output | ADDR_W | DRAM offset |
| resp_blocked | output | 1 | Write to a read-only window was dropped |

## Verification
The assertions check on every cycle the parts of the map that do not depend on configuration:
- the one-cycle latency of the result;
- that the target code is legal;
- that a blocked write only appears with a read-only target;
- the PCI hole below 4 GB;
- the remap above 4 GB.

Only the bench's scenarios can show the behaviour that depends on configuration. That covers the field position of each segment's attribute, the attribute-to-target mapping, and the SMRAM opening under the SMM and control bits. It also covers the all-PCI state after reset and a configuration write that does not affect an access in its own cycle.

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder #(
  parameter int ADDR_W = 36,
  parameter logic [ADDR_W-1:0] LOW_TOP  = 36'h0_E000_0000,
  parameter logic [ADDR_W-1:0] HIGH_END = 36'h1_2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              smm_active,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_idx,
  input  logic [7:0]        cfg_data,
  output logic              resp_valid,
  output logic [1:0]        resp_tgt,
  output logic [ADDR_W-1:0] resp_off,
  output logic              resp_blocked
);

  localparam int NBYTES = 8;
  localparam int SMR_IDX = NBYTES - 1;
  localparam logic [ADDR_W-1:0] FOUR_G   = ADDR_W'(64'h1_0000_0000);
  localparam logic [ADDR_W-1:0] SMR_LO   = ADDR_W'(32'h000A_0000);
  localparam logic [ADDR_W-1:0] SEG_LO   = ADDR_W'(32'h000C_0000);
  localparam logic [ADDR_W-1:0] TOPW_LO  = ADDR_W'(32'h000F_0000);
  localparam logic [ADDR_W-1:0] ONE_MEG  = ADDR_W'(32'h0010_0000);
  localparam logic [1:0] T_PCI = 2'd0, T_RAM = 2'd1, T_ROM = 2'd2;

  logic [7:0] cfg_q [NBYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBYTES; i++) cfg_q[i] <= 8'h00;
    end else if (cfg_we) begin
      cfg_q[cfg_idx] <= cfg_data;
    end
  end

  function automatic logic [1:0] attr_tgt(input logic [1:0] a);
    case (a)
      2'd3:    return T_RAM;
      2'd1:    return T_ROM;
      default: return T_PCI;
    endcase
  endfunction

  logic [3:0] seg;
  logic [7:0] seg_byte;
  logic [1:0] seg_attr;
  logic       smr_open;
  logic [1:0] tgt_d;
  logic [ADDR_W-1:0] off_d;

  assign seg      = req_addr[17:14];
  assign seg_byte = cfg_q[3'd1 + {1'b0, seg[3:1]}];
  assign seg_attr = seg[0] ? seg_byte[5:4] : seg_byte[1:0];
  assign smr_open = cfg_q[SMR_IDX][6] | (smm_active & cfg_q[SMR_IDX][3]);

  always_comb begin
    if (req_addr < SMR_LO)        tgt_d = T_RAM;
    else if (req_addr < SEG_LO)   tgt_d = smr_open ? T_RAM : T_PCI;
    else if (req_addr < TOPW_LO)  tgt_d = attr_tgt(seg_attr);
    else if (req_addr < ONE_MEG)  tgt_d = attr_tgt(cfg_q[0][5:4]);
    else if (req_addr < LOW_TOP)  tgt_d = T_RAM;
    else if (req_addr < FOUR_G)   tgt_d = T_PCI;
    else if (req_addr < HIGH_END) tgt_d = T_RAM;
    else                          tgt_d = T_PCI;

    if (tgt_d == T_PCI)           off_d = '0;
    else if (req_addr >= FOUR_G)  off_d = req_addr - FOUR_G + LOW_TOP;
    else                          off_d = req_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_tgt     <= T_PCI;
      resp_off     <= '0;
      resp_blocked <= 1'b0;
    end else begin
      resp_valid   <= req_valid;
      resp_blocked <= req_valid & req_write & (tgt_d == T_ROM);
      if (req_valid) begin
        resp_tgt <= tgt_d;
        resp_off <= off_d;
      end
    end
  end

endmodule

// File: rtl/legacy_mem_decoder_chk.sv
module legacy_mem_decoder_chk #(
  parameter int ADDR_W = 36,
  parameter logic [ADDR_W-1:0] LOW_TOP  = 36'h0_E000_0000,
  parameter logic [ADDR_W-1:0] HIGH_END = 36'h1_2000_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              resp_valid,
  input logic [1:0]        resp_tgt,
  input logic [ADDR_W-1:0] resp_off,
  input logic              resp_blocked
);
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  assert_legal_tgt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_tgt != 2'd3);

  assert_block_ro_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_blocked |-> (resp_valid && resp_tgt == 2'd2));

  assert_pci_hole_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= LOW_TOP && req_addr < FOUR_G)
      |=> (resp_tgt == 2'd0 && resp_off == '0));

  assert_high_remap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= FOUR_G && req_addr < HIGH_END)
      |=> (resp_tgt == 2'd1 && resp_off == $past(req_addr) - FOUR_G + LOW_TOP));
endmodule

bind legacy_mem_decoder legacy_mem_decoder_chk #(
  .ADDR_W(ADDR_W), .LOW_TOP(LOW_TOP), .HIGH_END(HIGH_END)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .resp_valid(resp_valid), .resp_tgt(resp_tgt), .resp_off(resp_off),
  .resp_blocked(resp_blocked)
);

// File: tb/sim_legacy_mem_decoder.sv
`timescale 1ns/1ps
module sim_legacy_mem_decoder;
  localparam int AW = 36;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, smm_active = 0, cfg_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_data = '0;
  logic resp_valid, resp_blocked;
  logic [1:0] resp_tgt;
  logic [AW-1:0] resp_off;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  legacy_mem_decoder u0 (.*);

  // {addr, write, smm, tgt, blocked, off}
  localparam int NV = 20;
  localparam logic [76:0] VEC [NV] = '{
    {36'h0_0000_1000, 1'b0, 1'b0, 2'd1, 1'b0, 36'h0_0000_1000},
    {36'h0_000F_0000, 1'b1, 1'b0, 2'd1, 1'b0, 36'h0_000F_0000},
    {36'h0_000C_0000, 1'b0, 1'b0, 2'd2, 1'b0, 36'h0_000C_0000},
    {36'h0_000C_3FFF, 1'b1, 1'b0, 2'd2, 1'b1, 36'h0_000C_3FFF},
    {36'h0_000C_4000, 1'b1, 1'b0, 2'd1, 1'b0, 36'h0_000C_4000},
    {36'h0_000C_8000, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0},
    {36'h0_000C_C000, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0},
    {36'h0_000E_8000, 1'b1, 1'b0, 2'd1, 1'b0, 36'h0_000E_8000},
    {36'h0_000E_FFFF, 1'b1, 1'b0, 2'd2, 1'b1, 36'h0_000E_FFFF},
    {36'h0_000A_0000, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0},
    {36'h0_000B_FFFF, 1'b0, 1'b1, 2'd1, 1'b0, 36'h0_000B_FFFF},
    {36'h0_0009_FFFF, 1'b1, 1'b0, 2'd1, 1'b0, 36'h0_0009_FFFF},
    {36'h0_0010_0000, 1'b0, 1'b0, 2'd1, 1'b0, 36'h0_0010_0000},
    {36'h0_DFFF_FFFF, 1'b0, 1'b0, 2'd1, 1'b0, 36'h0_DFFF_FFFF},
    {36'h0_E000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0},
    {36'h0_FFFF_FFFF, 1'b1, 1'b0, 2'd0, 1'b0, 36'h0},
    {36'h1_0000_0000, 1'b0, 1'b0, 2'd1, 1'b0, 36'h0_E000_0000},
    {36'h1_1FFF_FFFF, 1'b1, 1'b0, 2'd1, 1'b0, 36'h0_FFFF_FFFF},
    {36'h1_2000_0000, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0},
    {36'h0_000D_0000, 1'b0, 1'b0, 2'd0, 1'b0, 36'h0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input string req, input logic [AW-1:0] a, input logic w,
                        input logic s, input logic [1:0] et, input logic eb,
                        input logic [AW-1:0] eo);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_write = w; smm_active = s;
    @(negedge clk);
    req_valid = 0; req_write = 0; cfg_we = 0;
    chk({req, " valid R2"}, 64'(resp_valid), 64'd1);
    chk({req, " tgt"}, 64'(resp_tgt), 64'(et));
    chk({req, " blocked R7"}, 64'(resp_blocked), 64'(eb));
    chk({req, " off R11"}, 64'(resp_off), 64'(eo));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid after reset", 64'(resp_valid), 64'd0);
    access("R1 top window", 36'hF_0000, 0, 0, 2'd0, 0, 36'h0);
    access("R1 segment", 36'hC_4000, 0, 1, 2'd0, 0, 36'h0);
    access("R1 smram smm", 36'hA_0000, 0, 1, 2'd0, 0, 36'h0);
    access("R1 base ram", 36'h9_0000, 0, 0, 2'd1, 0, 36'h9_0000);
    // R2: idle cycle gives no result
    @(negedge clk);
    chk("R2 idle", 64'(resp_valid), 64'd0);

    // map for the table: R3 R4 R5 R6
    cfg(3'd0, 8'h30);
    cfg(3'd1, 8'h31);
    cfg(3'd2, 8'h20);
    cfg(3'd6, 8'h13);
    cfg(3'd7, 8'h08);
    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      v = VEC[i];
      access($sformatf("R3/R4/R5/R6/R8/R9 vec%0d", i), v[76:41], v[40], v[39],
             v[38:37], v[36], v[35:0]);
    end

    // R6: bit 6 opens without SMM
    cfg(3'd7, 8'h40);
    access("R6 bit6 open", 36'hA_8000, 1, 0, 2'd1, 0, 36'hA_8000);
    cfg(3'd7, 8'h00);
    access("R6 smm no bit", 36'hA_8000, 0, 1, 2'd0, 0, 36'h0);

    // R4: segment 5 odd nibble of byte 3; R10 same-cycle write ignored
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'd3; cfg_data = 8'h30;
    req_valid = 1; req_addr = 36'hD_4000; req_write = 0; smm_active = 0;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk("R10 same cycle tgt", 64'(resp_tgt), 64'd0);
    access("R10 next access R4 seg5", 36'hD_4000, 1, 0, 2'd1, 0, 36'hD_4000);
    access("R4 seg4 untouched", 36'hD_0000, 0, 0, 2'd0, 0, 36'h0);

    // R7: read of read-only not blocked
    cfg(3'd0, 8'h10);
    access("R7 ro read", 36'hF_8000, 0, 0, 2'd2, 0, 36'hF_8000);
    access("R7 ro write", 36'hF_8000, 1, 0, 2'd2, 1, 36'hF_8000);
    @(negedge clk);
    chk("R7 blocked one cycle", 64'(resp_blocked), 64'd0);

    // R1: reset again clears config
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    access("R1 cleared", 36'hF_8000, 0, 0, 2'd0, 0, 36'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule